// File: doc/BRIEF.md
# Peripheral ID Decision-Tree Lookup

This block turns a 12-bit peripheral identifier into an 8-bit channel index. The identifier is built from a 4-bit slave number and an 8-bit peripheral number. The block finds the channel by walking a binary decision tree held in an internal table of 255 words, each 32 bits wide. Each table word names one identifier bit to test. For each value of that bit, the word says either "continue at table word N" or "the answer is N".

Software or a boot sequencer fills the table through a simple write port. A requester then pulses `start` with the slave and peripheral numbers. The block visits one table word per clock. When the walk ends it raises `done` for exactly one cycle. In that cycle `found` tells whether a leaf was reached, and `result` carries the channel index.

The controller has two states: `S_IDLE` and `S_WALK`. There are four transitions:
- `S_IDLE` to `S_WALK` when `start` is seen.
- `S_WALK` to `S_WALK` when the selected branch points to another valid word and the visit budget is not used up.
- `S_WALK` to `S_IDLE` when a leaf is reached (found).
- `S_WALK` to `S_IDLE` when the branch target is 255 or higher, or when the sixteenth visited word still branches (both not found).

Top module: `pid_tree_lookup`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0, `result` is 0 and every table word reads as zero.
- R2: The tested identifier is `{slave_id, periph_num}`. Bit k with k in 0..7 is `periph_num[k]`, and k in 8..11 is `slave_id[k-8]`. A tested index of 12..15 reads as 0.
- R3: Table word layout: [21:18] index of the bit to test. For a tested bit of 0, [17] is the branch flag and [16:9] the value. For a tested bit of 1, [8] is the branch flag and [7:0] the value. Bits 31:22 are ignored.
- R4: The walk begins at word 0. If the flag for the tested bit value is 1, its value is the next word to visit. If the flag is 0, the walk ends with `found`=1 and `result` equal to that value.
- R5: One word is visited per clock. `done` is high exactly N cycles after the clock edge that accepted `start`, where N is the number of words visited. `busy` is high from the edge after acceptance until the edge that raises `done`.
- R6: If the sixteenth visited word still selects a branch, the walk ends with `found`=0 after 16 cycles. A leaf at the sixteenth word is still found.
- R7: A branch target of 255 or more ends the walk at once with `found`=0. That word counts as visited.
- R8: A `start` that arrives while `busy` is high is ignored. The running walk keeps its own identifier and timing.
- R9: `done` is a single-cycle pulse. Outside the `done` cycle, `found` and `result` are 0, and `result` is 0 when `found` is 0.
- R10: Pulsing `tbl_we` with `tbl_addr` below 255 replaces that word. The next lookup uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a lookup (accepted when idle) |
| slave_id | input | 4 | Upper four identifier bits |
| periph_num | input | 8 | Lower eight identifier bits |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table word to write |
| tbl_wdata | input | 32 | Table word value |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Leaf reached (valid with done) |
| result | output | 8 | Channel index (valid with done) |

## Verification
The bench builds the block with its default parameters: 255 table words, a 16-visit budget and a 4+8-bit identifier. With those values, a branch target of exactly 255 can be tested, as can a chain that ends either with a leaf on the sixteenth word or with a branch still pending there. Because the identifier is 12 bits but the bit index field reaches 15, the indices past the identifier width are also covered. Random tables full of random branches produce short leaves, loops that exhaust the budget and out-of-range pointers. Each random case is compared against a bench model of the walk for found, result and cycle count.

// File: rtl/pidl_pkg.sv
package pidl_pkg;

    localparam int WORD_W = 32;
    localparam int RES_W  = 8;
    localparam int SEL_W  = 4;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WALK = 1'b1
    } walk_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             br0;
        logic [RES_W-1:0] val0;
        logic             br1;
        logic [RES_W-1:0] val1;
    } node_t;

    function automatic node_t unpack_node(input logic [WORD_W-1:0] w);
        node_t n;
        n.sel  = w[21:18];
        n.br0  = w[17];
        n.val0 = w[16:9];
        n.br1  = w[8];
        n.val1 = w[7:0];
        return n;
    endfunction

endpackage

// File: rtl/pidl_node_table.sv
module pidl_node_table #(
    parameter int DEPTH  = 255,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] rows [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
        end else if (we && (32'(waddr) < DEPTH)) begin
            rows[waddr] <= wdata;
        end
    end

    assign rdata = (32'(raddr) < DEPTH) ? rows[raddr] : '0;

endmodule

// File: rtl/pidl_walker.sv
module pidl_walker
    import pidl_pkg::*;
#(
    parameter int ID_W       = 12,
    parameter int DEPTH      = 255,
    parameter int MAX_VISITS = 16,
    localparam int AW        = $clog2(DEPTH + 1),
    localparam int VW        = $clog2(MAX_VISITS),
    localparam int SPAN      = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   id_in,
    output logic [AW-1:0]     node_idx,
    input  logic [WORD_W-1:0] node_word,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [RES_W-1:0]  result
);

    walk_state_t      state_q, state_d;
    logic [ID_W-1:0]  id_q;
    logic [AW-1:0]    idx_q;
    logic [VW-1:0]    visit_q;

    node_t            node;
    logic [SPAN-1:0]  id_pad;
    logic             bit_val;
    logic             take_branch;
    logic [RES_W-1:0] target;
    logic             leaf;
    logic             bad_ptr;
    logic             budget_out;
    logic             finish;

    assign node        = unpack_node(node_word);
    assign id_pad      = SPAN'(id_q);
    assign bit_val     = id_pad[node.sel];
    assign take_branch = bit_val ? node.br1 : node.br0;
    assign target      = bit_val ? node.val1 : node.val0;
    assign leaf        = !take_branch;
    assign bad_ptr     = take_branch && (32'(target) >= DEPTH);
    assign budget_out  = take_branch && (visit_q == VW'(MAX_VISITS - 1));
    assign finish      = leaf || bad_ptr || budget_out;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)  state_d = S_WALK;
            S_WALK: if (finish) state_d = S_IDLE;
            default:            state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q    <= '0;
            idx_q   <= '0;
            visit_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    id_q    <= id_in;
                    idx_q   <= '0;
                    visit_q <= '0;
                end
                S_WALK: if (!finish) begin
                    idx_q   <= AW'(target);
                    visit_q <= visit_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            found  <= 1'b0;
            result <= '0;
        end else begin
            done   <= (state_q == S_WALK) && finish;
            found  <= (state_q == S_WALK) && leaf;
            result <= ((state_q == S_WALK) && leaf) ? target : '0;
        end
    end

    assign busy     = (state_q == S_WALK);
    assign node_idx = idx_q;

endmodule

// File: rtl/pid_tree_lookup.sv
module pid_tree_lookup
    import pidl_pkg::*;
#(
    parameter int SID_W      = 4,
    parameter int PNUM_W     = 8,
    parameter int DEPTH      = 255,
    parameter int MAX_VISITS = 16,
    localparam int ID_W      = SID_W + PNUM_W,
    localparam int AW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SID_W-1:0]  slave_id,
    input  logic [PNUM_W-1:0] periph_num,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [RES_W-1:0]  result
);

    logic [AW-1:0]     rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic [ID_W-1:0]   full_id;

    assign full_id = {slave_id, periph_num};

    pidl_node_table #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (rd_idx),
        .rdata (rd_word)
    );

    pidl_walker #(
        .ID_W       (ID_W),
        .DEPTH      (DEPTH),
        .MAX_VISITS (MAX_VISITS)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .id_in     (full_id),
        .node_idx  (rd_idx),
        .node_word (rd_word),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .result    (result)
    );

endmodule

// File: rtl/pid_tree_lookup_chk.sv
module pid_tree_lookup_chk #(
    parameter int MAX_VISITS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       found,
    input logic [7:0] result
);

    logic [15:0] walk_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    walk_len <= '0;
        else if (busy) walk_len <= walk_len + 1'b1;
        else           walk_len <= '0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!found && result == 8'd0)); // R9
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (result == 8'd0)); // R9
    AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R5
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R5
    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(walk_len) < MAX_VISITS)); // R6

endmodule

bind pid_tree_lookup pid_tree_lookup_chk #(.MAX_VISITS(MAX_VISITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .found  (found),
    .result (result)
);

// File: tb/pid_tree_lookup_tb.sv
module pid_tree_lookup_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  slave_id = '0;
    logic [7:0]  periph_num = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        busy, done, found;
    logic [7:0]  result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] tbl_m [255];

    always #2 clk = ~clk;

    pid_tree_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .slave_id(slave_id),
        .periph_num(periph_num), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .busy(busy), .done(done), .found(found),
        .result(result)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input int sel, input bit f0, input int v0,
                                       input bit f1, input int v1);
        return {10'd0, 4'(sel), f0, 8'(v0), f1, 8'(v1)};
    endfunction

    function automatic void model(input logic [11:0] id, output bit f,
                                  output logic [7:0] r, output int n);
        int idx = 0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w = tbl_m[idx];
            int sel = int'(w[21:18]);
            bit b = (sel < 12) ? id[sel] : 1'b0;
            bit fl = b ? w[8] : w[17];
            int t = b ? int'(w[7:0]) : int'(w[16:9]);
            if (!fl) begin f = 1; r = 8'(t); n = i + 1; return; end
            if (t >= 255) begin f = 0; r = 0; n = i + 1; return; end
            idx = t;
        end
        f = 0; r = 0; n = 16;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
        if (a < 255) tbl_m[a] = d;
    endtask

    task automatic lookup(input string tag, input logic [3:0] s, input logic [7:0] p,
                          input bit inject, input logic [7:0] p_alt);
        bit ef; logic [7:0] er; int en; int n = 0; bit got_f; int got_r;
        model({s, p}, ef, er, en);
        @(negedge clk);
        start = 1'b1; slave_id = s; periph_num = p;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (inject && k == 1) begin start = 1'b1; periph_num = p_alt; end
            else start = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done) break;
        end
        start = 1'b0;
        got_f = found; got_r = int'(result);
        check({tag, " found R4"}, int'(got_f), int'(ef));
        check({tag, " result R4"}, got_r, int'(er));
        check({tag, " cycles R5"}, n, en);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 255; i++) tbl_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("reset busy R1", int'(busy), 0);
        check("reset done R1", int'(done), 0);
        check("reset found R1", int'(found), 0);
        check("reset result R1", int'(result), 0);
        lookup("empty table R1", 4'h3, 8'h5A, 0, 0);

        // R3 / R2: field positions and bit numbering
        wr(0, mk(9, 0, 8'h11, 1, 5));
        wr(5, mk(0, 0, 8'h22, 0, 8'h33));
        lookup("sid bit R2", 4'h0, 8'h01, 0, 0);
        lookup("two level one R3", 4'h2, 8'h01, 0, 0);
        lookup("two level zero R3", 4'h2, 8'h00, 0, 0);
        wr(0, {10'h3FF, 4'd13, 1'b0, 8'h44, 1'b0, 8'h55});
        lookup("high index reads zero R2", 4'hF, 8'hFF, 0, 0);

        // R7 pointer at 255
        wr(0, mk(0, 1, 255, 0, 8'h77));
        lookup("bad pointer R7", 4'h0, 8'h00, 0, 0);
        lookup("leaf beside bad pointer R7", 4'h0, 8'h01, 0, 0);

        // R6 depth budget
        for (int i = 0; i < 16; i++) wr(i, mk(0, 1, i + 1, 1, i + 1));
        wr(16, mk(0, 0, 8'h99, 0, 8'h99));
        lookup("budget exhausted R6", 4'h1, 8'h00, 0, 0);
        wr(15, mk(0, 0, 8'h66, 0, 8'h67));
        lookup("leaf at sixteenth R6", 4'h1, 8'h00, 0, 0);
        lookup("leaf at sixteenth one R6", 4'h1, 8'h01, 0, 0);

        // R8 start during walk ignored
        lookup("start while busy R8", 4'h1, 8'h00, 1, 8'h01);

        // R10 rewrite takes effect
        wr(15, mk(0, 0, 8'hA5, 0, 8'hA5));
        lookup("rewrite R10", 4'h1, 8'h00, 0, 0);

        // random tables checked against the model (R4 R5 R6 R7)
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 255; i++)
                wr(i, mk($urandom_range(15, 0), $urandom_range(1, 0), $urandom_range(255, 0),
                         $urandom_range(1, 0), $urandom_range(255, 0)) |
                      {10'($urandom), 22'd0});
            for (int j = 0; j < 30; j++)
                lookup("random R4", 4'($urandom), 8'($urandom), 0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule